// File: doc/BRIEF.md
# ADC Autoscan Conversion Sequencer

This block is the digital controller that sits in front of a multi-channel successive-approximation converter core. It walks the converter's channel select upward from a software-chosen first channel to the highest channel. It hands the core one conversion at a time through a start/done handshake and stores each returned sample in a per-channel result slot. When the highest channel has been converted, it flags an end-of-sweep interrupt request.

Software writes one control word. That word holds the first channel, the single or repeat choice, the run bit, one enable for each of two trigger sources, and a sleep bit. A sweep begins when the run bit becomes set. Software can set it directly, or an enabled, active-low trigger input can set it: one trigger comes from a pin and one comes from an on-chip timer.

In single mode the run bit drops by itself after the highest channel. In repeat mode the controller returns to the first channel and goes on until software clears the run bit. The conversion already in flight is always allowed to finish. Triggers that arrive while the run bit is set have no effect. Results are read back through a registered read port that maps onto block RAM.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, ctrl_q, conv_start, conv_ch, eoc_irq and busy are all zero.
- R2: A sweep issues conversions on channels first, first+1, ... up to NCH-1 (7 by default), one conversion per accepted conv_done. A first channel of 7 converts only channel 7, and a first channel of 3 converts channels 3 to 7. Every conv_start follows either a run bit that is set while the block is idle, or the acceptance of a conv_done.
- R3: conv_start is a single-cycle pulse, and at most one conversion is outstanding. A conv_done is accepted only while busy is high and conv_start is low.
- R4: Each accepted conv_done writes conv_data into the slot of the channel in flight, replacing the old value. rd_data returns the slot selected by rd_ch one cycle later.
- R5: In single mode (ctrl bit 3 = 0), the run bit (ctrl bit 4) is cleared at the clock edge that accepts the done of channel 7. No further conv_start follows until the next start event.
- R6: eoc_irq pulses for exactly one cycle, one cycle after every accepted done of channel 7, in both modes.
- R7: In repeat mode (ctrl bit 3 = 1), the accepted done of channel 7 is followed on the next cycle by a conv_start on the first channel, for as long as the run bit stays set.
- R8: If software clears the run bit during a conversion, that conversion completes and its result is stored. The block then goes idle without issuing another conv_start.
- R9: Trigger inputs ext_trig_n and int_trig_n are active low. A falling edge on a source whose enable is set sets the run bit at the third clock edge after the input is first sampled low. The enables are ctrl bit 5 for the external input and ctrl bit 6 for the internal input. A low level held for many cycles counts as one event, and a source whose enable is clear has no effect.
- R10: A trigger event that occurs while the run bit is already set is ignored and does not restart or lengthen the sweep.
- R11: While the sleep bit (ctrl bit 7) is set, no conv_start is issued and a set run bit is held pending. The sweep starts once the sleep bit clears.
- R12: A write with reg_we loads the whole control word into ctrl_q: bits [2:0] first channel, bit 3 repeat mode, bit 4 run, bit 5 external enable, bit 6 internal enable, bit 7 sleep. The write takes priority over a hardware set or clear of the run bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| ctrl_q | output | 8 | Current control word, including the hardware-updated run bit |
| ext_trig_n | input | 1 | External trigger, active low |
| int_trig_n | input | 1 | Timer trigger, active low |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_ch | output | 3 | Channel select to the converter core |
| conv_done | input | 1 | Converter core result valid |
| conv_data | input | 10 | Converter core result |
| busy | output | 1 | A conversion is outstanding |
| eoc_irq | output | 1 | End-of-sweep request pulse |
| rd_ch | input | 3 | Result read channel |
| rd_data | output | 10 | Result of channel rd_ch, one cycle later |

## Verification
The assertions check the following on every cycle:
- the handshake shape: start pulses are single cycles, and none is issued while the sleep bit is set;
- end-of-sweep pulses are single cycles and are caused only by an accepted channel-7 done;
- single mode drops the run bit at the last done, and repeat mode wraps to the first channel.

The remaining behaviour can only be shown by the bench's scenarios, where a behavioural model is compared on every clock:
- the channel sequence for different first channels;
- stored results read back through the read port;
- triggers being synchronised, filtered by their enables, reduced to one event per low pulse and discarded during a sweep;
- a software stop in repeat mode letting the in-flight conversion land.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_WAIT = 1'b1
  } scan_state_t;

  // control word field offsets relative to the channel field width
  function automatic int f_cont(input int cw);
    return cw;
  endfunction
  function automatic int f_run(input int cw);
    return cw + 1;
  endfunction
  function automatic int f_ext(input int cw);
    return cw + 2;
  endfunction
  function automatic int f_int(input int cw);
    return cw + 3;
  endfunction
  function automatic int f_pd(input int cw);
    return cw + 4;
  endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int NSRC = 2,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] trig_n,
  input  logic [NSRC-1:0] enable,
  output logic            evt
);
  localparam int DEPTH = SYNC + 1;

  logic [NSRC-1:0] fall;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[DEPTH-2:0], trig_n[s]};
    end
    // high-to-low seen between the last synchroniser stage and its delayed copy
    assign fall[s] = pipe[DEPTH-1] & ~pipe[DEPTH-2];
  end

  assign evt = |(fall & enable);

endmodule

// File: rtl/adc_scan_cfg.sv
module adc_scan_cfg
  import adc_scan_pkg::*;
#(
  parameter int CW = 3,
  localparam int CTRL_W = CW + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              run_clr,
  input  logic              trig_evt,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam int B_RUN = f_run(CW);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (reg_we) begin
      ctrl_q <= reg_wdata;
    end else if (run_clr) begin
      ctrl_q[B_RUN] <= 1'b0;
    end else if (trig_evt) begin
      ctrl_q[B_RUN] <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          sleep,
  input  logic          cont,
  input  logic [CW-1:0] first_ch,
  input  logic          conv_done,
  output logic          conv_start,
  output logic [CW-1:0] conv_ch,
  output logic          busy,
  output logic          eoc_irq,
  output logic          run_clr,
  output logic          res_we
);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  scan_state_t state;
  logic done_acc, at_last, go;

  always_comb begin
    done_acc = (state == SC_WAIT) && conv_done && !conv_start;
    at_last  = (conv_ch == LAST);
    go       = run && !sleep;
    run_clr  = done_acc && at_last && !cont;
    res_we   = done_acc;
  end

  assign busy = (state == SC_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SC_IDLE;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      eoc_irq    <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      eoc_irq    <= done_acc && at_last;
      case (state)
        SC_IDLE: begin
          if (go) begin
            conv_start <= 1'b1;
            conv_ch    <= first_ch;
            state      <= SC_WAIT;
          end
        end
        SC_WAIT: begin
          if (done_acc) begin
            if (at_last) begin
              if (cont && go) begin
                conv_start <= 1'b1;
                conv_ch    <= first_ch;
              end else begin
                state <= SC_IDLE;
              end
            end else if (go) begin
              conv_start <= 1'b1;
              conv_ch    <= conv_ch + 1'b1;
            end else begin
              state <= SC_IDLE;
            end
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] wch,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rch,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[wch] <= wdata;
    rdata <= mem[rch];
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CW = $clog2(NCH),
  localparam int CTRL_W = CW + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  input  logic              ext_trig_n,
  input  logic              int_trig_n,
  output logic              conv_start,
  output logic [CW-1:0]     conv_ch,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  output logic              busy,
  output logic              eoc_irq,
  input  logic [CW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_data
);
  localparam int B_CONT = f_cont(CW);
  localparam int B_RUN  = f_run(CW);
  localparam int B_EXT  = f_ext(CW);
  localparam int B_INT  = f_int(CW);
  localparam int B_PD   = f_pd(CW);

  logic trig_evt, run_clr, res_we;

  adc_trig_edge #(.NSRC(2), .SYNC(2)) u_trig (
    .clk    (clk),
    .rst    (rst),
    .trig_n ({int_trig_n, ext_trig_n}),
    .enable ({ctrl_q[B_INT], ctrl_q[B_EXT]}),
    .evt    (trig_evt)
  );

  adc_scan_cfg #(.CW(CW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .run_clr   (run_clr),
    .trig_evt  (trig_evt),
    .ctrl_q    (ctrl_q)
  );

  adc_scan_fsm #(.NCH(NCH)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl_q[B_RUN]),
    .sleep      (ctrl_q[B_PD]),
    .cont       (ctrl_q[B_CONT]),
    .first_ch   (ctrl_q[CW-1:0]),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_ch    (conv_ch),
    .busy       (busy),
    .eoc_irq    (eoc_irq),
    .run_clr    (run_clr),
    .res_we     (res_we)
  );

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk   (clk),
    .we    (res_we),
    .wch   (conv_ch),
    .wdata (conv_data),
    .rch   (rd_ch),
    .rdata (rd_data)
  );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int CTRL_W = CW + 5
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              conv_start,
  input logic [CW-1:0]     conv_ch,
  input logic              conv_done,
  input logic              busy,
  input logic              eoc_irq
);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  logic acc_last;
  assign acc_last = conv_done && busy && !conv_start && (conv_ch == LAST);

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  a_r6_eoc_pulse: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |=> !eoc_irq);

  a_r6_eoc_cause: assert property (@(posedge clk) disable iff (rst)
    eoc_irq |-> $past(acc_last));

  a_r6_eoc_follows: assert property (@(posedge clk) disable iff (rst)
    acc_last |=> eoc_irq);

  a_r11_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> !$past(ctrl_q[CW+4]));

  a_r5_single_clear: assert property (@(posedge clk) disable iff (rst)
    (acc_last && !ctrl_q[CW] && !reg_we) |=> !ctrl_q[CW+1] && !busy);

  a_r7_wrap_first: assert property (@(posedge clk) disable iff (rst)
    (acc_last && ctrl_q[CW] && ctrl_q[CW+1] && !ctrl_q[CW+4])
      |=> conv_start && conv_ch == $past(ctrl_q[CW-1:0]));

endmodule

bind adc_scan_ctrl adc_scan_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .ctrl_q     (ctrl_q),
  .conv_start (conv_start),
  .conv_ch    (conv_ch),
  .conv_done  (conv_done),
  .busy       (busy),
  .eoc_irq    (eoc_irq)
);

// File: tb/test_adc_scan_ctrl.sv
module test_adc_scan_ctrl;
  localparam int NCH = 8;
  localparam int DW  = 10;
  localparam int CW  = 3;
  localparam int LAT = 3;
  localparam int LASTC = NCH - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_q;
  logic ext_trig_n = 1'b1, int_trig_n = 1'b1;
  logic conv_start, busy, eoc_irq;
  logic [CW-1:0] conv_ch;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [CW-1:0] rd_ch = '0;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_starts = 0, n_eoc = 0;

  always #5 clk = ~clk;

  adc_scan_ctrl #(.NCH(NCH), .DW(DW)) i_adc_scan_ctrl (
    .clk, .rst, .reg_we, .reg_wdata, .ctrl_q, .ext_trig_n, .int_trig_n,
    .conv_start, .conv_ch, .conv_done, .conv_data, .busy, .eoc_irq,
    .rd_ch, .rd_data
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctrl;
  logic m_wait, m_start, m_eoc;
  int m_ch;
  logic [2:0] eh, ih;
  int res [NCH];
  bit written [NCH];

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_wait = 0; m_start = 0; m_eoc = 0; m_ch = 0;
      eh = 3'b111; ih = 3'b111;
      foreach (written[i]) written[i] = 0;
    end else begin
      bit evt, done, clr, go;
      int first;
      evt = (m_ctrl[5] && eh[2] && !eh[1]) || (m_ctrl[6] && ih[2] && !ih[1]);
      done = conv_done && m_wait && !m_start;
      clr = done && m_ch == LASTC && !m_ctrl[3];
      go = m_ctrl[4] && !m_ctrl[7];
      first = m_ctrl[2:0];
      m_eoc = done && m_ch == LASTC;
      if (done) begin res[m_ch] = conv_data; written[m_ch] = 1; end
      m_start = 0;
      if (!m_wait) begin
        if (go) begin m_start = 1; m_ch = first; m_wait = 1; end
      end else if (done) begin
        if (m_ch == LASTC) begin
          if (m_ctrl[3] && go) begin m_start = 1; m_ch = first; end
          else m_wait = 0;
        end else if (go) begin m_start = 1; m_ch = m_ch + 1; end
        else m_wait = 0;
      end
      if (reg_we) m_ctrl = reg_wdata;
      else if (clr) m_ctrl[4] = 0;
      else if (evt) m_ctrl[4] = 1;
      eh = {eh[1:0], ext_trig_n};
      ih = {ih[1:0], int_trig_n};
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk("R3 conv_start", conv_start, m_start);
      chk("R2 conv_ch", conv_ch, m_ch);
      chk("R6 eoc_irq", eoc_irq, m_eoc);
      chk("R7 busy", busy, m_wait);
      chk("R12 ctrl_q", ctrl_q, m_ctrl);
      if (conv_start) n_starts++;
      if (eoc_irq) n_eoc++;
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // converter core stand-in
  int cv_cnt = 0, cv_ch = 0, seq = 0;
  bit cv_busy = 0;
  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (cv_busy) begin
      if (cv_cnt == 0) begin
        conv_done <= 1'b1;
        conv_data <= DW'((cv_ch * 37 + seq * 11) % 1024);
        seq++;
        cv_busy = 0;
      end else cv_cnt--;
    end
    if (conv_start) begin cv_busy = 1; cv_cnt = LAT; cv_ch = conv_ch; end
  end

  function automatic logic [7:0] mk(int first, bit cont, bit run, bit ee, bit ie, bit pd);
    return {pd, ie, ee, run, cont, 3'(first)};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy && !ctrl_q[4]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic readback();
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk); rd_ch = 3'(c);
      @(negedge clk);
      if (written[c]) chk("R4 rd_data", rd_data, res[c]);
    end
  endtask

  task automatic pulse(input bit ext, input int len);
    @(negedge clk);
    if (ext) ext_trig_n = 1'b0; else int_trig_n = 1'b0;
    repeat (len) @(negedge clk);
    ext_trig_n = 1'b1; int_trig_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl_q", ctrl_q, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 eoc_irq", eoc_irq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 conv_ch", conv_ch, 0);
    rst = 1'b0;

    // R2/R5: single sweep from channel 3
    n_starts = 0; n_eoc = 0;
    wr(mk(3, 0, 1, 0, 0, 0));
    wait_idle();
    chk("R2 conversions from 3", n_starts, 5);
    chk("R6 one eoc per sweep", n_eoc, 1);
    chk("R5 run cleared", ctrl_q[4], 0);
    readback();

    // R2: first channel 7
    n_starts = 0;
    wr(mk(7, 0, 1, 0, 0, 0));
    wait_idle();
    chk("R2 only channel 7", n_starts, 1);

    // R2/R4: full sweep from 0 overwrites old results
    n_starts = 0;
    wr(mk(0, 0, 1, 0, 0, 0));
    wait_idle();
    chk("R2 conversions from 0", n_starts, 8);
    readback();

    // R7/R8: repeat mode, two laps then software stop
    n_starts = 0; n_eoc = 0;
    wr(mk(5, 1, 1, 0, 0, 0));
    for (int i = 0; i < 2000 && n_eoc < 2; i++) @(negedge clk);
    chk("R7 two laps", n_eoc, 2);
    repeat (2) @(negedge clk);
    wr(mk(5, 1, 0, 0, 0, 0));
    wait_idle();
    chk("R8 idle after stop", busy, 0);
    chk("R8 run clear", ctrl_q[4], 0);
    readback();

    // R9/R10: external trigger, long low pulse, repeat pulse during sweep
    n_starts = 0;
    wr(mk(4, 0, 0, 1, 0, 0));
    pulse(1, 6);
    repeat (6) @(negedge clk);
    pulse(1, 2);
    wait_idle();
    chk("R10 one sweep despite extra trigger", n_starts, 4);
    n_starts = 0;
    pulse(1, 2);
    repeat (6) @(negedge clk);
    wait_idle();
    chk("R9 trigger after sweep restarts", n_starts, 4);

    // R9: disabled internal source does nothing
    n_starts = 0;
    pulse(0, 3);
    repeat (20) @(negedge clk);
    chk("R9 disabled source", n_starts, 0);
    chk("R9 run stays clear", ctrl_q[4], 0);

    // R9: internal source enabled, repeat mode, further triggers ignored (R10)
    n_eoc = 0;
    wr(mk(6, 1, 0, 0, 1, 0));
    pulse(0, 4);
    repeat (10) @(negedge clk);
    pulse(0, 2);
    for (int i = 0; i < 2000 && n_eoc < 3; i++) @(negedge clk);
    chk("R10 repeat laps", n_eoc, 3);
    wr(mk(6, 1, 0, 0, 1, 0));
    wait_idle();

    // R11: sleep holds start off
    n_starts = 0;
    wr(mk(2, 0, 1, 0, 0, 1));
    repeat (30) @(negedge clk);
    chk("R11 no start while asleep", n_starts, 0);
    chk("R11 run held", ctrl_q[4], 1);
    wr(mk(2, 0, 1, 0, 0, 0));
    wait_idle();
    chk("R11 sweep after wake", n_starts, 6);
    readback();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule